// File: doc/BRIEF.md
# Table Jump Execution Unit

This unit executes the two compressed table-jump instructions of a 32- or 64-bit RISC-V core: a plain jump through a table and a jump through a table that also links. The core hands it a 16-bit instruction word, the PC of that instruction, the BASE and MODE fields of the jump-table CSR, and a verdict from the privilege logic on whether table jumps are allowed. When the instruction is allowed, the unit computes the table-entry address and issues one fetch on a valid/ready memory port. It then waits for the read data or for an access fault.

When the table entry arrives, the unit clears bit 0 of the entry and presents it as a redirect PC. For the linking form it also writes PC+2 to x1. A disallowed instruction, a nonzero MODE or a faulting fetch produces a one-cycle trap report instead. The trap report carries the cause, the instruction's PC as epc, and a tval. Faults leave x1 untouched. The fetch address is treated as physical.

Top module: `tbljmp_unit`

## Requirements
- R1: An instruction belongs to the family only when bits 15:10 are 101000 and bits 1:0 are 10. An issue of any other word is ignored: no fetch, no result, and busy stays low.
- R2: If the MODE input is nonzero, the unit reports a trap with cause 2 (illegal instruction), epc equal to the PC, and tval equal to the zero-extended instruction word. No fetch is issued.
- R3: If the deny input is set, the unit reports a trap and issues no fetch. The cause is 22 (virtual instruction) when deny_virt is set, and 2 otherwise. tval is the instruction word. Deny takes priority over MODE.
- R4: When bits 9:7 are zero, the instruction is the plain form with index = bits 6:2. The fetch address is {BASE, 6'b0} + index*XLEN/8.
- R5: When bits 9:7 are nonzero, the instruction is the linking form with an 8-bit index = bits 9:2, which is 32 or greater. Its fetch address follows the R4 formula. On a fault-free completion it pulses link_we with link_data = PC+2.
- R6: On a fault-free completion, redirect_valid pulses for one cycle. redirect_pc equals the fetched entry with bit 0 forced to 0.
- R7: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen. busy is high from the cycle after issue until the result cycle, inclusive.
- R8: A fetch response with the fault bit set reports a trap with cause 1 (instruction access fault), epc = PC and tval = the fetch address. It gives no link write and no redirect.
- R9: issue_valid is ignored while busy. The result reflects only the instruction that started the operation.
- R10: After reset the unit is idle: busy, mem_req_valid, redirect_valid, trap_valid and link_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Offer an instruction (taken when idle) |
| issue_instr | input | 16 | Compressed instruction word |
| issue_pc | input | XLEN | PC of the instruction |
| tbl_base | input | XLEN-6 | BASE field of the jump-table CSR |
| tbl_mode | input | 6 | MODE field of the jump-table CSR |
| deny | input | 1 | Privilege logic forbids table jumps |
| deny_virt | input | 1 | Forbidden case is a virtual-instruction trap |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Table fetch request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Fetch response present |
| mem_rsp_data | input | XLEN | Fetched table entry |
| mem_rsp_fault | input | 1 | Fetch response is an access fault |
| redirect_valid | output | 1 | One-cycle jump result |
| redirect_pc | output | XLEN | New PC, bit 0 clear |
| link_we | output | 1 | Write link_data into x1 |
| link_data | output | XLEN | Return address PC+2 |
| trap_valid | output | 1 | One-cycle trap report |
| trap_cause | output | 5 | Exception cause code |
| trap_epc | output | XLEN | PC of the table-jump instruction |
| trap_tval | output | XLEN | Instruction word or faulting entry address |

## Verification
The assertions assume that the memory side sends a response only after it has accepted a request, and only one response per request. They also assume that the CSR and verdict inputs are valid whenever issue_valid is high. The bench acts as the memory and keeps within these rules: it raises ready with random delays, returns exactly one response at a random delay after acceptance, and drives the instruction fields only alongside issue_valid. While an operation is in flight, the bench sends stray issue attempts. It also mixes random indices, bases, faults and verdicts with directed corner indices 0, 31, 32 and 255.

// File: rtl/tbljmp_unit.sv
module tbljmp_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [15:0]     issue_instr,
  input  logic [XLEN-1:0] issue_pc,
  input  logic [XLEN-7:0] tbl_base,
  input  logic [5:0]      tbl_mode,
  input  logic            deny,
  input  logic            deny_virt,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_fault,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            trap_valid,
  output logic [4:0]      trap_cause,
  output logic [XLEN-1:0] trap_epc,
  output logic [XLEN-1:0] trap_tval
);
  localparam int SH = (XLEN == 64) ? 3 : 2;
  localparam logic [4:0] C_FETCH = 5'd1, C_ILL = 5'd2, C_VIRT = 5'd22;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [XLEN-1:0] q_pc, q_addr, q_res;
  logic            q_link, q_trap;
  logic [4:0]      q_cause;

  wire            in_family = issue_instr[15:10] == 6'b101000 && issue_instr[1:0] == 2'b10;
  wire [7:0]      idx       = issue_instr[9:2];
  wire            is_link   = |issue_instr[9:7];
  wire [XLEN-1:0] ent_addr  = {tbl_base, 6'b0} + ({{(XLEN-8){1'b0}}, idx} << SH);
  wire            start     = st == S_IDLE && issue_valid && in_family;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      q_pc    <= '0;
      q_addr  <= '0;
      q_res   <= '0;
      q_link  <= 1'b0;
      q_trap  <= 1'b0;
      q_cause <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          q_pc   <= issue_pc;
          q_addr <= ent_addr;
          q_link <= is_link;
          if (deny || tbl_mode != 6'd0) begin
            q_trap  <= 1'b1;
            q_cause <= (deny && deny_virt) ? C_VIRT : C_ILL;
            q_res   <= {{(XLEN-16){1'b0}}, issue_instr};
            st      <= S_RESP;
          end else begin
            q_trap <= 1'b0;
            st     <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          q_trap  <= mem_rsp_fault;
          q_cause <= C_FETCH;
          q_res   <= mem_rsp_fault ? q_addr : {mem_rsp_data[XLEN-1:1], 1'b0};
          st      <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy           = st != S_IDLE;
  assign mem_req_valid  = st == S_REQ;
  assign mem_req_addr   = q_addr;
  assign redirect_valid = st == S_RESP && !q_trap;
  assign trap_valid     = st == S_RESP && q_trap;
  assign redirect_pc    = q_res;
  assign trap_tval      = q_res;
  assign trap_cause     = q_cause;
  assign trap_epc       = q_pc;
  assign link_we        = redirect_valid && q_link;
  assign link_data      = q_pc + 2;

  // R7: request held until accepted
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R4: entry address aligned to the entry size
  a_r4_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[SH-1:0] == '0);
  // R6: target has bit 0 clear
  a_r6_even_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !redirect_pc[0]);
  // R8: no link write alongside a trap
  a_r8_no_link_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !link_we && !redirect_valid);
  // R9: captured PC frozen while busy
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(trap_epc));
endmodule

// File: tb/tbljmp_unit_tb_top.sv
module tbljmp_unit_tb_top;
  localparam int XLEN = 32;
  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, deny = 0, deny_virt = 0;
  logic [15:0] issue_instr = 0;
  logic [XLEN-1:0] issue_pc = 0;
  logic [XLEN-7:0] tbl_base = 0;
  logic [5:0] tbl_mode = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_fault = 0;
  logic [XLEN-1:0] mem_rsp_data = 0;
  logic busy, mem_req_valid, redirect_valid, link_we, trap_valid;
  logic [XLEN-1:0] mem_req_addr, redirect_pc, link_data, trap_epc, trap_tval;
  logic [4:0] trap_cause;

  int n_chk = 0, n_bad = 0;

  tbljmp_unit #(.XLEN(XLEN)) dut_i (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_addr(logic [XLEN-7:0] b, logic [15:0] ins);
    return {b, 6'b0} + (XLEN'(ins[9:2]) * (XLEN/8));
  endfunction

  task automatic run(logic [15:0] ins, logic [XLEN-1:0] pc, logic [XLEN-7:0] b,
                     logic [5:0] md, logic dn, logic dv, logic flt, logic [XLEN-1:0] dat);
    bit fam = ins[15:10] == 6'b101000 && ins[1:0] == 2'b10;
    bit lnk = |ins[9:7];
    bit exp_fetch = fam && !dn && md == 0;
    int phase = 0, dly = 0, nreq = 0;
    bit got_r = 0, got_t = 0, got_l = 0;
    logic [XLEN-1:0] r_pc = 0, l_dat = 0, t_epc = 0, t_tval = 0;
    logic [4:0] t_cause = 0;
    @(negedge clk);
    issue_valid = 1; issue_instr = ins; issue_pc = pc; tbl_base = b;
    tbl_mode = md; deny = dn; deny_virt = dv;
    @(negedge clk);
    issue_valid = 0;
    for (int c = 0; c < 40; c++) begin
      if (redirect_valid || trap_valid) begin
        got_r = redirect_valid; got_t = trap_valid; got_l = link_we;
        r_pc = redirect_pc; l_dat = link_data; t_epc = trap_epc;
        t_tval = trap_tval; t_cause = trap_cause;
        break;
      end
      mem_req_ready = 0; mem_rsp_valid = 0; issue_valid = 0;
      if (phase == 0 && mem_req_valid) begin
        if (nreq == 0) chk("R4/R5 fetch address", mem_req_addr, exp_addr(b, ins));
        nreq++;
        if ($urandom % 2) begin mem_req_ready = 1; phase = 1; dly = $urandom % 3; end
      end else if (phase == 1) begin
        issue_valid = 1; issue_instr = 16'hA00A; issue_pc = ~pc; tbl_base = ~b;
        if (dly == 0) begin
          mem_rsp_valid = 1; mem_rsp_fault = flt; mem_rsp_data = dat; phase = 2;
        end else dly--;
      end
      @(negedge clk);
    end
    issue_valid = 0; mem_req_ready = 0; mem_rsp_valid = 0;
    if (!fam) begin
      chk("R1 foreign word ignored", {busy, mem_req_valid, got_r, got_t}, 0);
      return;
    end
    chk("R2/R3 fetch issued only when allowed", nreq != 0, exp_fetch);
    if (!exp_fetch) begin
      chk("R2/R3 trap", {got_t, got_r, got_l}, 3'b100);
      chk("R2/R3 cause", t_cause, dn ? (dv ? 22 : 2) : 2);
      chk("R2/R3 epc/tval", {t_epc, t_tval}, {pc, XLEN'(ins)});
    end else if (flt) begin
      chk("R8 fault trap", {got_t, got_r, got_l}, 3'b100);
      chk("R8 cause/epc/tval", {t_cause, t_epc, t_tval}, {5'd1, pc, exp_addr(b, ins)});
    end else begin
      chk("R6 redirect", {got_t, got_r}, 2'b01);
      chk("R6 target bit0 clear", r_pc, {dat[XLEN-1:1], 1'b0});
      chk("R5 link write", got_l, lnk);
      if (lnk) chk("R5 link value", l_dat, pc + 2);
    end
    @(negedge clk);
    chk("R7/R9 idle after result", busy, 0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    #1;
    chk("R10 reset outputs", {busy, mem_req_valid, redirect_valid, trap_valid, link_we}, 0);
    #20 rst_n = 1;
    run(16'hA002, 32'h100, 26'h1, 0, 0, 0, 0, 32'h8001);
    run({9'h140, 5'd31, 2'b10}, 32'h204, 26'h3, 0, 0, 0, 0, 32'h7777);
    run({6'b101000, 8'd32, 2'b10}, 32'h300, 26'h5, 0, 0, 0, 0, 32'h1235);
    run({6'b101000, 8'd255, 2'b10}, 32'h400, 26'h3FFFFFF, 0, 0, 0, 0, 32'hFFFFFFFF);
    run({6'b101000, 8'd40, 2'b10}, 32'h500, 26'h9, 6'd1, 0, 0, 0, 0);
    run({6'b101000, 8'd40, 2'b10}, 32'h600, 26'h9, 6'd1, 1, 1, 0, 0);
    run({6'b101000, 8'd3, 2'b10}, 32'h700, 26'h9, 0, 1, 0, 0, 0);
    run({6'b101000, 8'd77, 2'b10}, 32'h800, 26'h11, 0, 0, 0, 1, 32'h55);
    run(16'hA001, 32'h900, 26'h1, 0, 0, 0, 0, 0);
    run(16'h8002, 32'h900, 26'h1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] w = {6'b101000, 8'($urandom), 2'b10};
      if ($urandom % 10 == 0) w = 16'($urandom);
      run(w, {$urandom, 1'b0}, 26'($urandom), ($urandom % 8 == 0) ? 6'($urandom | 1) : 6'd0,
          $urandom % 8 == 0, $urandom % 2, $urandom % 5 == 0, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule